// File: doc/BRIEF.md
# Microsequencer with Multiway Branch

This block chooses the next control-store address for a machine run by 32-bit microwords. It does not need an incrementing program counter. Every microword names its own successor. Up to three of the low offset bits of that successor can be replaced by qualifier bits. Each qualifier is either a fixed 0/1 or one selected bit of an 8-bit status input. One microword can therefore dispatch to any entry of an aligned group of up to eight words.

The control store is divided into modules of 64 words. An address is an 8-bit module number followed by a 6-bit word offset. Ordinary, dispatching and looping words always stay inside the current module. Only a module-switch word or a call can reach another module. A single link register holds one return point for call/return pairs. A loop word repeats itself until a chosen condition becomes true.

The store has a combinational read. The block presents `cs_addr` and receives the word at that address on `cs_word` in the same cycle. At the clock edge it moves to the next address and copies the word into its control register for the datapath. Byte 0 of the word (bits 7:0) holds the word type in bits 2:0, and bits 31:24 hold the next-address information.

Top module: `microseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `cs_addr`, `ctrl_word` and `ret_err` all become 0 and the link register becomes invalid.
- R2: After each clock edge out of reset, `ctrl_word` equals the `cs_word` that was presented during the preceding cycle.
- R3: A plain word (type code 0, and the unused codes 6 and 7) goes next to the current module at offset `cs_word[29:24]`. The qualifier count in `cs_word[31:30]` is ignored for these words.
- R4: A module-switch word (type code 2) goes next to module `cs_word[23:16]` at offset `cs_word[29:24]`.
- R5: A dispatch word (type code 1) stays in the current module. It takes the offset `cs_word[29:24]` and replaces the low n bits with qualifiers, where n is `cs_word[31:30]`. The first qualifier fills the most significant of those n bits.
- R6: Qualifier selectors are 4 bits each. The first is at `cs_word[11:8]`, the second at `[15:12]` and the third at `[19:16]`. If selector bit 3 is 1, the qualifier is `status[sel[2:0]]`. If it is 0, the qualifier is the constant `sel[0]`.
- R7: A dispatch word with a qualifier count of 0 goes to `cs_word[29:24]` unchanged, whatever the selectors and status hold.
- R8: A call word (type code 3) goes to module `cs_word[23:16]`, offset `cs_word[29:24]`. It stores the current module with offset (current offset + 1) mod 64 as the link. A return word (type code 4) with a valid link goes there and invalidates the link. The link has one level, so a second call overwrites the first return point.
- R9: A return word while no link is valid keeps `cs_addr` unchanged, and `ret_err` is 1 for the following cycle. `ret_err` is 0 after any other word.
- R10: A loop word (type code 5) holds `cs_addr` while the first qualifier is 0. Once the first qualifier is 1, it goes to the current module at offset `cs_word[29:24]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_word | input | 32 | Microword read from the control store at `cs_addr` |
| status | input | 8 | Status bits that qualifiers can select |
| cs_addr | output | 14 | Current control-store address {module, offset} |
| ctrl_word | output | 32 | Control register: the microword being executed |
| ret_err | output | 1 | Return attempted with no valid link, one cycle |

## Verification
The bench builds the block with its default values: 8-bit modules, 6-bit offsets, an 8-bit status input and three qualifiers. These values make reachable the full three-qualifier dispatch, including the group entry with constant and status qualifiers mixed. They also make reachable the two- and one-qualifier forms, and offset wraparound from 63 to 0 when a link is formed. Module numbers are wide enough to show that a call and its return cross modules, while plain, dispatch and loop words keep the module bits.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

   typedef enum logic [2:0] {
      K_SEQ  = 3'd0,
      K_BR   = 3'd1,
      K_MOD  = 3'd2,
      K_CALL = 3'd3,
      K_RET  = 3'd4,
      K_LOOP = 3'd5,
      K_RSV6 = 3'd6,
      K_RSV7 = 3'd7
   } kind_e;

   localparam int KIND_LSB = 0;
   localparam int SEL_LSB  = 8;
   localparam int MODF_LSB = 16;
   localparam int NXT_LSB  = 24;

endpackage

// File: rtl/mseq_qual.sv
module mseq_qual #(
   parameter int STAT_W = 8,
   parameter int QMAX   = 3,
   localparam int IDX_W = $clog2(STAT_W),
   localparam int SEL_W = IDX_W + 1
) (
   input  logic [QMAX*SEL_W-1:0] sel_i,
   input  logic [STAT_W-1:0]     status_i,
   output logic [QMAX-1:0]       qual_o
);

   if (STAT_W != (1 << IDX_W)) begin : g_bad_stat
      $error("mseq_qual: STAT_W must be a power of two");
   end

   for (genvar i = 0; i < QMAX; i++) begin : g_q
      logic [SEL_W-1:0] sel;
      assign sel = sel_i[i*SEL_W +: SEL_W];
      assign qual_o[i] = sel[SEL_W-1] ? status_i[sel[IDX_W-1:0]] : sel[0];
   end

endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch #(
   parameter int OFF_W = 6,
   parameter int QMAX  = 3,
   localparam int QCNT_W = $clog2(QMAX + 1),
   localparam int QI_W   = (QMAX > 1) ? $clog2(QMAX) : 1
) (
   input  logic [OFF_W-1:0]  base_i,
   input  logic [QCNT_W-1:0] qcnt_i,
   input  logic [QMAX-1:0]   qual_i,
   output logic [OFF_W-1:0]  off_o
);

   if (QMAX > OFF_W) begin : g_bad_q
      $error("mseq_dispatch: QMAX exceeds offset width");
   end

   logic [QI_W-1:0] qidx;

   always_comb begin
      off_o = base_i;
      qidx  = '0;
      for (int j = 0; j < QMAX; j++) begin
         if (j < int'(qcnt_i)) begin
            qidx     = QI_W'(int'(qcnt_i) - 1 - j);
            off_o[j] = qual_i[qidx];
         end
      end
   end

endmodule

// File: rtl/mseq_link.sv
module mseq_link #(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              save_i,
   input  logic [ADDR_W-1:0] save_addr_i,
   input  logic              take_i,
   output logic [ADDR_W-1:0] link_o,
   output logic              valid_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         link_o  <= '0;
         valid_o <= 1'b0;
      end else if (save_i) begin
         link_o  <= save_addr_i;
         valid_o <= 1'b1;
      end else if (take_i) begin
         valid_o <= 1'b0;
      end
   end

   // R8
   link_set_chk: assert property (@(posedge clk) disable iff (rst)
      save_i |=> (valid_o && link_o == $past(save_addr_i)));

   // R8
   link_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (take_i && !save_i) |=> !valid_o);

endmodule

// File: rtl/microseq_top.sv
module microseq_top #(
   parameter int MOD_W  = 8,
   parameter int OFF_W  = 6,
   parameter int STAT_W = 8,
   parameter int QMAX   = 3,
   parameter int WORD_W = 32,
   localparam int ADDR_W = MOD_W + OFF_W,
   localparam int IDX_W  = $clog2(STAT_W),
   localparam int SEL_W  = IDX_W + 1,
   localparam int QCNT_W = $clog2(QMAX + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] cs_word,
   input  logic [STAT_W-1:0] status,
   output logic [ADDR_W-1:0] cs_addr,
   output logic [WORD_W-1:0] ctrl_word,
   output logic              ret_err
);
   import mseq_pkg::*;

   if (mseq_pkg::NXT_LSB + OFF_W + QCNT_W > WORD_W) begin : g_bad_nxt
      $error("microseq_top: next-address field does not fit the word");
   end
   if (MOD_W > mseq_pkg::NXT_LSB - mseq_pkg::MODF_LSB) begin : g_bad_mod
      $error("microseq_top: module field wider than its byte");
   end
   if (mseq_pkg::SEL_LSB + QMAX * SEL_W > mseq_pkg::NXT_LSB) begin : g_bad_sel
      $error("microseq_top: selectors overlap next-address byte");
   end

   kind_e              kind;
   logic [MOD_W-1:0]   cur_mod, f_mod;
   logic [OFF_W-1:0]   cur_off, f_off, disp_off;
   logic [QCNT_W-1:0]  f_qcnt;
   logic [QMAX-1:0]    qv;
   logic [ADDR_W-1:0]  link_addr, nxt_addr, ret_point;
   logic               link_valid, do_call, do_ret, bad_ret;

   assign kind    = kind_e'(cs_word[mseq_pkg::KIND_LSB +: 3]);
   assign cur_mod = cs_addr[ADDR_W-1 -: MOD_W];
   assign cur_off = cs_addr[OFF_W-1:0];
   assign f_mod   = cs_word[mseq_pkg::MODF_LSB +: MOD_W];
   assign f_off   = cs_word[mseq_pkg::NXT_LSB +: OFF_W];
   assign f_qcnt  = cs_word[mseq_pkg::NXT_LSB + OFF_W +: QCNT_W];

   assign do_call   = (kind == K_CALL);
   assign do_ret    = (kind == K_RET);
   assign bad_ret   = do_ret && !link_valid;
   assign ret_point = {cur_mod, cur_off + OFF_W'(1)};

   mseq_qual #(.STAT_W(STAT_W), .QMAX(QMAX)) u_qual (
      .sel_i    (cs_word[mseq_pkg::SEL_LSB +: QMAX*SEL_W]),
      .status_i (status),
      .qual_o   (qv)
   );

   mseq_dispatch #(.OFF_W(OFF_W), .QMAX(QMAX)) u_disp (
      .base_i (f_off),
      .qcnt_i (f_qcnt),
      .qual_i (qv),
      .off_o  (disp_off)
   );

   mseq_link #(.ADDR_W(ADDR_W)) u_link (
      .clk         (clk),
      .rst         (rst),
      .save_i      (do_call),
      .save_addr_i (ret_point),
      .take_i      (do_ret),
      .link_o      (link_addr),
      .valid_o     (link_valid)
   );

   always_comb begin
      unique case (kind)
         K_BR:         nxt_addr = {cur_mod, disp_off};
         K_MOD,
         K_CALL:       nxt_addr = {f_mod, f_off};
         K_RET:        nxt_addr = link_valid ? link_addr : cs_addr;
         K_LOOP:       nxt_addr = qv[0] ? {cur_mod, f_off} : cs_addr;
         default:      nxt_addr = {cur_mod, f_off};
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_addr   <= '0;
         ctrl_word <= '0;
         ret_err   <= 1'b0;
      end else begin
         cs_addr   <= nxt_addr;
         ctrl_word <= cs_word;
         ret_err   <= bad_ret;
      end
   end

   // R3
   mod_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (kind inside {K_SEQ, K_BR, K_LOOP, K_RSV6, K_RSV7})
      |=> cs_addr[ADDR_W-1 -: MOD_W] == $past(cs_addr[ADDR_W-1 -: MOD_W]));

   // R9
   bad_ret_chk: assert property (@(posedge clk) disable iff (rst)
      (do_ret && !link_valid) |=> ($stable(cs_addr) && ret_err));

   // R10
   loop_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (kind == K_LOOP && cs_word[mseq_pkg::SEL_LSB + SEL_W - 1]
       && !status[cs_word[mseq_pkg::SEL_LSB +: IDX_W]]) |=> $stable(cs_addr));

   // R4
   mod_switch_chk: assert property (@(posedge clk) disable iff (rst)
      (kind == K_MOD) |=> cs_addr[ADDR_W-1 -: MOD_W] == $past(cs_word[mseq_pkg::MODF_LSB +: MOD_W]));

endmodule

// File: tb/sim_microseq_top.sv
module sim_microseq_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] cs_word;
   logic [7:0]  status;
   logic [13:0] cs_addr;
   logic [31:0] ctrl_word;
   logic        ret_err;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   microseq_top u0 (
      .clk(clk), .rst(rst), .cs_word(cs_word), .status(status),
      .cs_addr(cs_addr), .ctrl_word(ctrl_word), .ret_err(ret_err)
   );

   function automatic logic [31:0] mk(input logic [2:0] k, input logic [1:0] qc,
                                      input logic [5:0] off, input logic [7:0] b2,
                                      input logic [7:0] b1);
      return {qc, off, b2, b1, 5'b0, k};
   endfunction

   function automatic logic [13:0] ad(input logic [7:0] m, input logic [5:0] o);
      return {m, o};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input logic [31:0] w, input logic [7:0] s);
      cs_word = w;
      status  = s;
      @(posedge clk);
      #2;
   endtask

   task automatic t_reset;
      rst = 1'b1; cs_word = 32'hFFFF_FFFF; status = 8'hFF;
      repeat (3) @(posedge clk);
      #2;
      rst = 1'b0;
      chk("R1 addr", 32'(cs_addr), 32'h0);
      chk("R1 ctrl", ctrl_word, 32'h0);
      chk("R1 err", 32'(ret_err), 32'h0);
   endtask

   task automatic t_plain;
      logic [31:0] w;
      w = mk(3'd0, 2'd0, 6'd5, 8'h11, 8'h22);
      step(w, 8'h00);
      chk("R3 plain", 32'(cs_addr), 32'(ad(8'h00, 6'd5)));
      chk("R2 ctrl", ctrl_word, w);
      step(mk(3'd6, 2'd3, 6'd9, 8'h0F, 8'hFF), 8'hFF);
      chk("R3 reserved type ignores count", 32'(cs_addr), 32'(ad(8'h00, 6'd9)));
   endtask

   task automatic t_module;
      step(mk(3'd2, 2'd0, 6'h11, 8'h2A, 8'h00), 8'h00);
      chk("R4 switch", 32'(cs_addr), 32'(ad(8'h2A, 6'h11)));
      step(mk(3'd0, 2'd0, 6'h3F, 8'h99, 8'h00), 8'h00);
      chk("R3 module kept", 32'(cs_addr), 32'(ad(8'h2A, 6'h3F)));
   endtask

   task automatic t_dispatch;
      step(mk(3'd1, 2'd3, 6'h18, 8'h0D, 8'hC1), 8'h20);
      chk("R5 R6 3-way S4=0 S5=1", 32'(cs_addr), 32'(ad(8'h2A, 6'h1D)));
      step(mk(3'd1, 2'd3, 6'h18, 8'h0D, 8'hC1), 8'h10);
      chk("R5 R6 3-way S4=1 S5=0", 32'(cs_addr), 32'(ad(8'h2A, 6'h1E)));
      step(mk(3'd1, 2'd2, 6'h30, 8'h00, 8'h08), 8'h01);
      chk("R5 two qualifiers", 32'(cs_addr), 32'(ad(8'h2A, 6'h32)));
      step(mk(3'd1, 2'd1, 6'h10, 8'h00, 8'h01), 8'h00);
      chk("R6 one constant qualifier", 32'(cs_addr), 32'(ad(8'h2A, 6'h11)));
      step(mk(3'd1, 2'd0, 6'h07, 8'hFF, 8'hFF), 8'hFF);
      chk("R7 zero qualifiers", 32'(cs_addr), 32'(ad(8'h2A, 6'h07)));
   endtask

   task automatic t_call;
      step(mk(3'd3, 2'd0, 6'h20, 8'h03, 8'h00), 8'h00);
      chk("R8 call target", 32'(cs_addr), 32'(ad(8'h03, 6'h20)));
      step(mk(3'd4, 2'd0, 6'h00, 8'h00, 8'h00), 8'h00);
      chk("R8 return", 32'(cs_addr), 32'(ad(8'h2A, 6'h08)));
      chk("R9 good return no error", 32'(ret_err), 32'h0);
      step(mk(3'd2, 2'd0, 6'h3F, 8'h05, 8'h00), 8'h00);
      step(mk(3'd3, 2'd0, 6'h00, 8'h01, 8'h00), 8'h00);
      step(mk(3'd4, 2'd0, 6'h15, 8'h00, 8'h00), 8'h00);
      chk("R8 return offset wraps", 32'(cs_addr), 32'(ad(8'h05, 6'h00)));
   endtask

   task automatic t_badret;
      step(mk(3'd4, 2'd0, 6'h2C, 8'h07, 8'h00), 8'h00);
      chk("R9 hold", 32'(cs_addr), 32'(ad(8'h05, 6'h00)));
      chk("R9 flag", 32'(ret_err), 32'h1);
      step(mk(3'd0, 2'd0, 6'h04, 8'h00, 8'h00), 8'h00);
      chk("R9 flag clears", 32'(ret_err), 32'h0);
      chk("R3 after bad return", 32'(cs_addr), 32'(ad(8'h05, 6'h04)));
   endtask

   task automatic t_loop;
      step(mk(3'd5, 2'd0, 6'h30, 8'h00, 8'h0A), 8'h00);
      chk("R10 loop hold 1", 32'(cs_addr), 32'(ad(8'h05, 6'h04)));
      step(mk(3'd5, 2'd0, 6'h30, 8'h00, 8'h0A), 8'hFB);
      chk("R10 loop hold 2", 32'(cs_addr), 32'(ad(8'h05, 6'h04)));
      step(mk(3'd5, 2'd0, 6'h30, 8'h00, 8'h0A), 8'h04);
      chk("R10 loop exit", 32'(cs_addr), 32'(ad(8'h05, 6'h30)));
   endtask

   task automatic t_overwrite;
      step(mk(3'd3, 2'd0, 6'h00, 8'h06, 8'h00), 8'h00);
      step(mk(3'd3, 2'd0, 6'h00, 8'h07, 8'h00), 8'h00);
      chk("R8 nested call", 32'(cs_addr), 32'(ad(8'h07, 6'h00)));
      step(mk(3'd4, 2'd0, 6'h00, 8'h00, 8'h00), 8'h00);
      chk("R8 link overwritten", 32'(cs_addr), 32'(ad(8'h06, 6'h01)));
      step(mk(3'd4, 2'd0, 6'h00, 8'h00, 8'h00), 8'h00);
      chk("R8 single level", 32'(cs_addr), 32'(ad(8'h06, 6'h01)));
      chk("R9 second return flagged", 32'(ret_err), 32'h1);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_plain();
      t_module();
      t_dispatch();
      t_call();
      t_badret();
      t_loop();
      t_overwrite();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule